// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the shared control and status register file of a multi-channel DMA engine. It is placed between a simple memory-mapped register bus and the channel sequencers. Each channel has four kinds of per-channel bits:

- a freeze control;
- a reset request;
- a completion flag with its interrupt enable;
- an error interrupt flag with an error-cause bit.

Each kind takes one bit per channel in one half of a 32-bit word. Every register word can be reached at four addresses: a plain write, a set alias, a clear alias and a toggle alias. Software can therefore change single bits without a read-modify-write. Clearing a flag acknowledges the interrupt it raised.

The sequencers report events as one-cycle pulses: completion, termination error and bus error. The block turns these into sticky flags and drives one registered interrupt line per channel. It also issues a one-cycle reset strobe to a channel. That strobe is held back while the channel reports its read-flush state, because resetting a channel in that state can stall it. Each channel's state code can also be read back at an address in a per-channel window with a fixed stride.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every register word reads 0. The freeze, reset strobe and interrupt outputs are all 0.
- R2: The control word is at 0x00, the completion word at 0x10 and the error word at 0x20. Within each word, offset +0x0 replaces the word, +0x4 ORs in the written ones, +0x8 clears the written ones and +0xC inverts the written ones. Any of the four addresses reads the word.
- R3: Bits 15:0 of the control word are per-channel freeze bits, and `freeze_o` follows them from the clock edge that writes them.
- R4: A `ch_done_i` pulse sets the channel's sticky completion flag (bit n of the completion word). A hardware set wins over a software clear in the same cycle. Bits 31:16 of the completion word are the interrupt enables.
- R5: `irq_o[n]` equals (completion flag AND enable) OR error flag, registered one cycle after the flags.
- R6: A termination error pulse sets error flag n (bit n of the error word) and clears cause bit n+16. A bus error pulse sets the flag and sets the cause bit. Error interrupts do not depend on the enables.
- R7: Completion and termination error in the same cycle count as completion only, with no error flag. Completion and bus error in the same cycle set both flags.
- R8: Setting reset request bit n+16 of the control word gives a one-cycle `rst_strobe_o[n]` pulse on the next edge. While the channel's state code equals 0x8 (read flush), the strobe is deferred until the code changes.
- R9: The reset request bit clears itself on the edge that issues its strobe.
- R10: Reads return data on `bus_rdata_o` with `bus_rvalid_o` one cycle after `bus_rd_i`. Address 0x150 + n*0x70 returns channel n's 4-bit state code in bits 3:0. Undecoded addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |
| ch_state_i | input | 64 | 4-bit state code per channel |
| ch_done_i | input | 16 | Completion pulse per channel |
| ch_term_err_i | input | 16 | Termination error pulse per channel |
| ch_bus_err_i | input | 16 | Bus error pulse per channel |
| freeze_o | output | 16 | Per-channel freeze level |
| rst_strobe_o | output | 16 | Per-channel one-cycle reset strobe |
| irq_o | output | 16 | Per-channel interrupt line |

## Verification
The results fall due at fixed latencies:

- Register contents and `freeze_o` change on the edge that samples a write or an event pulse.
- `irq_o` follows one edge later.
- A reset strobe appears on the edge after its request bit is stored, or on the first edge after the read-flush code goes away.
- Read data is due on the edge that samples `bus_rd_i`.

The bench drives each stimulus one nanosecond after an edge and samples just after the edge it has computed for that result. It also samples the edge before for the lagging interrupt and strobe outputs, so a result that is one cycle early or late is caught. Every channel is swept for freeze, completion, both error kinds, coincident events, deferred and immediate resets, and state readback.

// File: rtl/dma_chan_csr_pkg.sv
`timescale 1ns/1ps
package dma_chan_csr_pkg;

  // Address bits [3:2] choose how a write combines with the stored word.
  typedef enum logic [1:0] {
    AOP_WRITE = 2'd0,
    AOP_SET   = 2'd1,
    AOP_CLR   = 2'd2,
    AOP_TGL   = 2'd3
  } alias_op_e;

  function automatic logic alias_apply(input alias_op_e op, input logic cur, input logic b);
    case (op)
      AOP_WRITE: alias_apply = b;
      AOP_SET:   alias_apply = cur | b;
      AOP_CLR:   alias_apply = cur & ~b;
      default:   alias_apply = cur ^ b;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_csr_dec.sv
`timescale 1ns/1ps
module dma_chan_csr_dec
  import dma_chan_csr_pkg::*;
#(
  parameter int AW          = 12,
  parameter int NCH         = 16,
  parameter int CTL_OFS     = 'h00,
  parameter int CMP_OFS     = 'h10,
  parameter int ERR_OFS     = 'h20,
  parameter int CHAN_BASE   = 'h150,
  parameter int CHAN_STRIDE = 'h70,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0] addr_i,
  output logic          sel_ctl_o,
  output logic          sel_cmp_o,
  output logic          sel_err_o,
  output alias_op_e     op_o,
  output logic          chan_hit_o,
  output logic [CW-1:0] chan_idx_o
);

  assign sel_ctl_o = (addr_i[AW-1:4] == (AW-4)'(CTL_OFS >> 4));
  assign sel_cmp_o = (addr_i[AW-1:4] == (AW-4)'(CMP_OFS >> 4));
  assign sel_err_o = (addr_i[AW-1:4] == (AW-4)'(ERR_OFS >> 4));
  assign op_o      = alias_op_e'(addr_i[3:2]);

  always_comb begin
    chan_hit_o = 1'b0;
    chan_idx_o = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(CHAN_BASE + n * CHAN_STRIDE)) begin
        chan_hit_o = 1'b1;
        chan_idx_o = CW'(n);
      end
    end
  end

endmodule

// File: rtl/dma_chan_csr_slice.sv
`timescale 1ns/1ps
module dma_chan_csr_slice
  import dma_chan_csr_pkg::*;
#(
  parameter int              SW         = 4,
  parameter logic [SW-1:0]   FLUSH_CODE = SW'(8)
) (
  input  logic          clk,
  input  logic          rst,
  input  alias_op_e     op_i,
  input  logic          wr_ctl_i,
  input  logic          wr_cmp_i,
  input  logic          wr_err_i,
  input  logic          b_lo_i,
  input  logic          b_hi_i,
  input  logic [SW-1:0] state_i,
  input  logic          done_i,
  input  logic          term_i,
  input  logic          berr_i,
  output logic          freeze_o,
  output logic          req_o,
  output logic          strobe_o,
  output logic          cmp_o,
  output logic          en_o,
  output logic          errf_o,
  output logic          cause_o,
  output logic          irq_o
);

  logic sw_freeze, sw_req, sw_cmp, sw_en, sw_errf, sw_cause;
  logic deliver, err_evt;

  always_comb begin
    sw_freeze = wr_ctl_i ? alias_apply(op_i, freeze_o, b_lo_i) : freeze_o;
    sw_req    = wr_ctl_i ? alias_apply(op_i, req_o,    b_hi_i) : req_o;
    sw_cmp    = wr_cmp_i ? alias_apply(op_i, cmp_o,    b_lo_i) : cmp_o;
    sw_en     = wr_cmp_i ? alias_apply(op_i, en_o,     b_hi_i) : en_o;
    sw_errf   = wr_err_i ? alias_apply(op_i, errf_o,   b_lo_i) : errf_o;
    sw_cause  = wr_err_i ? alias_apply(op_i, cause_o,  b_hi_i) : cause_o;
  end

  // A pending reset goes out only when the channel is not flushing.
  assign deliver = req_o && (state_i != FLUSH_CODE);
  // A termination reported with completion is absorbed as completion.
  assign err_evt = berr_i | (term_i & ~done_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_o <= 1'b0;
      req_o    <= 1'b0;
      strobe_o <= 1'b0;
      cmp_o    <= 1'b0;
      en_o     <= 1'b0;
      errf_o   <= 1'b0;
      cause_o  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      freeze_o <= sw_freeze;
      req_o    <= deliver ? 1'b0 : sw_req;
      strobe_o <= deliver;
      cmp_o    <= sw_cmp | done_i;
      en_o     <= sw_en;
      errf_o   <= sw_errf | err_evt;
      cause_o  <= err_evt ? berr_i : sw_cause;
      irq_o    <= (cmp_o & en_o) | errf_o;
    end
  end

endmodule

// File: rtl/dma_chan_csr.sv
`timescale 1ns/1ps
module dma_chan_csr
  import dma_chan_csr_pkg::*;
#(
  parameter int AW          = 12,
  parameter int NCH         = 16,
  parameter int SW          = 4,
  parameter int CHAN_BASE   = 'h150,
  parameter int CHAN_STRIDE = 'h70,
  localparam int DW         = 2 * NCH,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [NCH*SW-1:0] ch_state_i,
  input  logic [NCH-1:0]    ch_done_i,
  input  logic [NCH-1:0]    ch_term_err_i,
  input  logic [NCH-1:0]    ch_bus_err_i,
  output logic [NCH-1:0]    freeze_o,
  output logic [NCH-1:0]    rst_strobe_o,
  output logic [NCH-1:0]    irq_o
);

  logic          sel_ctl, sel_cmp, sel_err, chan_hit;
  alias_op_e     op;
  logic [CW-1:0] chan_idx;

  logic [NCH-1:0] rst_req_v, cmp_v, cmp_en_v, errf_v, cause_v;
  logic [DW-1:0]  rd_word;

  dma_chan_csr_dec #(
    .AW(AW), .NCH(NCH), .CHAN_BASE(CHAN_BASE), .CHAN_STRIDE(CHAN_STRIDE)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .sel_ctl_o (sel_ctl),
    .sel_cmp_o (sel_cmp),
    .sel_err_o (sel_err),
    .op_o      (op),
    .chan_hit_o(chan_hit),
    .chan_idx_o(chan_idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_csr_slice #(.SW(SW)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .op_i     (op),
      .wr_ctl_i (bus_wr_i & sel_ctl),
      .wr_cmp_i (bus_wr_i & sel_cmp),
      .wr_err_i (bus_wr_i & sel_err),
      .b_lo_i   (bus_wdata_i[g]),
      .b_hi_i   (bus_wdata_i[g+NCH]),
      .state_i  (ch_state_i[g*SW +: SW]),
      .done_i   (ch_done_i[g]),
      .term_i   (ch_term_err_i[g]),
      .berr_i   (ch_bus_err_i[g]),
      .freeze_o (freeze_o[g]),
      .req_o    (rst_req_v[g]),
      .strobe_o (rst_strobe_o[g]),
      .cmp_o    (cmp_v[g]),
      .en_o     (cmp_en_v[g]),
      .errf_o   (errf_v[g]),
      .cause_o  (cause_v[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_comb begin
    rd_word = '0;
    if (sel_ctl)       rd_word = {rst_req_v, freeze_o};
    else if (sel_cmp)  rd_word = {cmp_en_v, cmp_v};
    else if (sel_err)  rd_word = {cause_v, errf_v};
    else if (chan_hit) rd_word[SW-1:0] = ch_state_i[chan_idx*SW +: SW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_rd_i;
      if (bus_rd_i) bus_rdata_o <= rd_word;
    end
  end

endmodule

// File: rtl/dma_chan_csr_chk.sv
`timescale 1ns/1ps
module dma_chan_csr_chk #(
  parameter int NCH = 16,
  parameter int SW  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic [NCH*SW-1:0] ch_state_i,
  input logic [NCH-1:0]    ch_done_i,
  input logic [NCH-1:0]    ch_term_err_i,
  input logic [NCH-1:0]    ch_bus_err_i,
  input logic [NCH-1:0]    rst_strobe_o,
  input logic [NCH-1:0]    irq_o,
  input logic [NCH-1:0]    rst_req_v,
  input logic [NCH-1:0]    cmp_v,
  input logic [NCH-1:0]    cmp_en_v,
  input logic [NCH-1:0]    errf_v
);

  logic [NCH-1:0] flushing;
  always_comb begin
    for (int n = 0; n < NCH; n++) flushing[n] = (ch_state_i[n*SW +: SW] == SW'(8));
  end

  // R8: no strobe comes from an edge where that channel was flushing
  a_r8_no_strobe_in_flush: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rst_strobe_o & $past(flushing)) == '0));

  // R8: a strobe lasts one cycle
  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rst_strobe_o & $past(rst_strobe_o)) == '0));

  // R9: the request is gone once its strobe is out
  a_r9_strobe_clears_req: assert property (@(posedge clk) disable iff (rst)
    (rst_strobe_o & rst_req_v) == '0);

  // R5: interrupt lines follow the flags one cycle later
  a_r5_irq_tracks_flags: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past((cmp_v & cmp_en_v) | errf_v)));

  // R4: a completion pulse always leaves its flag set
  a_r4_done_sticks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cmp_v & $past(ch_done_i)) == $past(ch_done_i)));

  // R7: termination together with completion raises no new error flag
  a_r7_term_with_done: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr_i)) |->
      ((errf_v & ~$past(errf_v) & $past(ch_done_i & ch_term_err_i & ~ch_bus_err_i)) == '0));

endmodule

bind dma_chan_csr dma_chan_csr_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr_i     (bus_wr_i),
  .ch_state_i   (ch_state_i),
  .ch_done_i    (ch_done_i),
  .ch_term_err_i(ch_term_err_i),
  .ch_bus_err_i (ch_bus_err_i),
  .rst_strobe_o (rst_strobe_o),
  .irq_o        (irq_o),
  .rst_req_v    (rst_req_v),
  .cmp_v        (cmp_v),
  .cmp_en_v     (cmp_en_v),
  .errf_v       (errf_v)
);

// File: tb/dma_chan_csr_tb_top.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;

  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [63:0] state = '0;
  logic [15:0] done = '0, term = '0, berr = '0;
  logic [15:0] freeze, strobe, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_chan_csr dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .ch_state_i(state), .ch_done_i(done), .ch_term_err_i(term), .ch_bus_err_i(berr),
    .freeze_o(freeze), .rst_strobe_o(strobe), .irq_o(irq)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick;
    wr = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick;
    rd = 1'b0;
    chk("R10 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] bit_n;
    repeat (3) tick;
    rst = 1'b0;
    tick;

    // R1 reset values
    rd32(12'h000, d); chk("R1 ctl", d, 0);
    rd32(12'h010, d); chk("R1 cmp", d, 0);
    rd32(12'h020, d); chk("R1 err", d, 0);
    chk("R1 outs", {freeze, strobe}, 0);
    chk("R1 irq", {16'd0, irq}, 0);

    // R2 alias behaviour
    wr32(12'h010, 32'hA5A5_0000); rd32(12'h010, d); chk("R2 write", d, 32'hA5A5_0000);
    wr32(12'h014, 32'h0000_00FF); rd32(12'h014, d); chk("R2 set", d, 32'hA5A5_00FF);
    wr32(12'h018, 32'h0000_000F); rd32(12'h018, d); chk("R2 clr", d, 32'hA5A5_00F0);
    wr32(12'h01C, 32'h0001_0011); rd32(12'h01C, d); chk("R2 tgl", d, 32'hA5A4_00E1);
    wr32(12'h010, 32'h0);
    wr32(12'h02C, 32'h0003_0001); rd32(12'h020, d); chk("R2 err tgl", d, 32'h0003_0001);
    chk("R5 err irq", {16'd0, irq}, 32'h1);
    wr32(12'h028, 32'hFFFF_FFFF); tick;
    chk("R5 irq drop", {16'd0, irq}, 0);

    // R3 freeze sweep
    for (int ch = 0; ch < NCH; ch++) begin
      wr32(12'h004, 32'(1) << ch);
      chk("R3 freeze", {16'd0, freeze}, (32'(1) << (ch + 1)) - 1);
    end
    wr32(12'h008, 32'h0000_FFFF);
    chk("R3 unfreeze", {16'd0, freeze}, 0);

    // R4 / R5 completion sweep
    wr32(12'h014, 32'hFFFF_0000);
    for (int ch = 0; ch < NCH; ch++) begin
      bit_n = 32'(1) << ch;
      done = bit_n[15:0]; tick; done = '0;
      chk("R5 irq lag", {16'd0, irq}, 0);
      tick;
      chk("R5 irq", {16'd0, irq}, bit_n);
      rd32(12'h010, d); chk("R4 flag", d, 32'hFFFF_0000 | bit_n);
      wr32(12'h018, bit_n); tick;
      chk("R5 ack", {16'd0, irq}, 0);
    end

    // R5 enable gating
    wr32(12'h018, 32'h0008_0000);
    done = 16'h0008; tick; done = '0; tick; tick;
    chk("R5 gated", {16'd0, irq}, 0);
    rd32(12'h010, d); chk("R4 gated flag", d, 32'hFFF7_0008);
    wr32(12'h018, 32'h0000_0008);

    // R4 hardware set beats software clear
    done = 16'h0004; tick; done = '0;
    done = 16'h0004; wr32(12'h018, 32'h0000_0004); done = '0;
    rd32(12'h010, d); chk("R4 hw wins", d, 32'hFFF7_0004);
    wr32(12'h010, 32'h0); tick;

    // R6 error sweep with enables off
    for (int ch = 0; ch < NCH; ch++) begin
      bit_n = 32'(1) << ch;
      term = bit_n[15:0]; tick; term = '0; tick;
      chk("R6 term irq", {16'd0, irq}, bit_n);
      rd32(12'h020, d); chk("R6 term", d, bit_n);
      wr32(12'h028, bit_n);
      berr = bit_n[15:0]; tick; berr = '0;
      rd32(12'h020, d); chk("R6 bus", d, bit_n | (bit_n << 16));
      wr32(12'h028, 32'hFFFF_FFFF); tick;
      chk("R6 ack", {16'd0, irq}, 0);
    end

    // R7 coincident events
    for (int ch = 0; ch < NCH; ch++) begin
      bit_n = 32'(1) << ch;
      done = bit_n[15:0]; term = bit_n[15:0]; tick; done = '0; term = '0;
      rd32(12'h020, d); chk("R7 term+done err", d, 0);
      rd32(12'h010, d); chk("R7 term+done cmp", d, bit_n);
      wr32(12'h018, 32'h0000_FFFF);
      done = bit_n[15:0]; berr = bit_n[15:0]; tick; done = '0; berr = '0;
      rd32(12'h020, d); chk("R7 bus+done err", d, bit_n | (bit_n << 16));
      rd32(12'h010, d); chk("R7 bus+done cmp", d, bit_n);
      wr32(12'h018, 32'h0000_FFFF);
      wr32(12'h028, 32'hFFFF_FFFF);
    end
    tick; tick;

    // R8 / R9 reset strobes, immediate and deferred
    for (int ch = 0; ch < NCH; ch++) begin
      bit_n = 32'(1) << ch;
      wr32(12'h004, bit_n << 16);
      chk("R8 no early strobe", {16'd0, strobe}, 0);
      tick;
      chk("R8 strobe", {16'd0, strobe}, bit_n);
      rd32(12'h000, d); chk("R9 self clear", d, 0);
      chk("R8 one cycle", {16'd0, strobe}, 0);
      state[ch*4 +: 4] = 4'h8;
      wr32(12'h004, bit_n << 16);
      repeat (3) tick;
      chk("R8 deferred", {16'd0, strobe}, 0);
      rd32(12'h000, d); chk("R8 pending", d, bit_n << 16);
      state[ch*4 +: 4] = 4'h0;
      tick;
      chk("R8 released", {16'd0, strobe}, bit_n);
      tick;
      chk("R8 released one cycle", {16'd0, strobe}, 0);
      rd32(12'h000, d); chk("R9 cleared", d, 0);
    end

    // R10 per-channel state window
    for (int ch = 0; ch < NCH; ch++) state[ch*4 +: 4] = 4'(ch) ^ 4'h5;
    for (int ch = 0; ch < NCH; ch++) begin
      rd32(12'(32'h150 + ch * 32'h70), d);
      chk("R10 state", d, {28'd0, 4'(ch) ^ 4'h5});
    end
    rd32(12'h040, d); chk("R10 undecoded", d, 0);
    state = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule